// File: doc/BRIEF.md
# In-System Configuration Instruction Controller

This block sits behind a JTAG test access port on a reprogrammable configuration memory. It owns a 16-bit instruction register and a set of data registers, and it keeps the small amount of device state a programming host needs. That state is a configuration-mode flag, per-sector write-protect and blank flags, a sector-select register, a busy timer for erase and program operations, and two sticky error flags. The TAP state machine is outside the block. It supplies capture, shift and update strobes for the instruction and data paths, all sampled on the rising edge of `tck`.

A host first enters configuration mode. It then loads a sector mask into the select register and triggers an erase or a program. It polls the instruction capture value, or the operation-status register, until the operation completes, and it reads back the blank-check and write-protect registers. Protection can be added freely. It can be removed only through the unlock instruction, and an unlocked sector must be erased before it will accept programming again. The flash array itself is modelled only by its blank flags.

Top module: `isc_tap_ctrl`

## Requirements
- R1: After `trst_n` is asserted, the instruction register selects bypass (16'hFFFF), configuration mode is off, no operation is busy, both error flags and the done flag are clear, every write-protect and blank bit reads 1, and the select register is zero.
- R2: Capture-IR loads the value {7'b0, 1'b0, cfg_err, 1'b0, prog_err, ~busy, mode, 3'b001}: bit 3 is the mode flag, bit 4 is low while busy, bit 5 (with bit 6 low) flags a program error, and bit 7 (with bit 8 low) flags a configuration error.
- R3: Update-IR with 16'h00E8 sets configuration mode and clears the configuration error; 16'h00F0 clears the mode; the next instruction capture shows the new mode.
- R4: 16'hFFFF and any opcode not listed here select a 1-bit bypass data register that captures 0, so TDO follows TDI one shift later.
- R5: Opcodes 16'h00EC and 16'h55AA select the 24-bit select register; capture returns its current value and every update loads it, in or out of configuration mode. Bit i of the low byte names sector i.
- R6: Update-DR under 16'h00EC, in configuration mode and not busy, marks each selected unprotected sector blank (its bit cleared). Selected protected sectors are left alone, and the program error is set exactly when one was selected. The busy timer then starts.
- R7: Update-IR of 16'h00EA, in configuration mode and not busy, marks each sector named by the select register that is unprotected and not awaiting erase as programmed (blank bit set). The program error is set exactly when a named sector was refused, and the busy timer starts.
- R8: An accepted erase or program holds busy for BUSY_CYCLES clock cycles and clears the done flag. When the time expires, busy clears and done sets. Done is bit 2 of the 8-bit status register (16'h00E3), whose other bits read 0. Erase and program requests made while busy are ignored.
- R9: Opcode 16'h00F7 selects a 16-bit write-protect register reading {8'hFF, flags}, where a 0 in bit i marks sector i protected and bits at or above the sector count read 1. An update in configuration mode can only clear flags: writing 1 over a 0 has no effect.
- R10: Update-DR under 16'h55AA, in configuration mode and not busy, sets the protect flags of the selected sectors to 1 and marks them as awaiting erase; such sectors refuse programming (program error) until erased.
- R11: Opcode 16'h000D selects an 8-bit blank-check register; bit i is 0 when sector i is blank, and bits at or above the sector count read 1.
- R12: Outside configuration mode, erase, program, unlock and write-protect updates change no sector state and set the configuration error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data in |
| capture_ir | input | 1 | Capture strobe for the instruction path |
| shift_ir | input | 1 | Shift strobe for the instruction path |
| update_ir | input | 1 | Update strobe for the instruction path |
| capture_dr | input | 1 | Capture strobe for the data path |
| shift_dr | input | 1 | Shift strobe for the data path |
| update_dr | input | 1 | Update strobe for the data path |
| tdo | output | 1 | Serial data out, bit 0 of the active shift register |

## Verification
The bench builds the block with three sectors and a busy time of 100 cycles. With three sectors, the padding bits at and above the sector count show up in both the blank-check and write-protect values. With 100 cycles, a capture taken right after an erase shows the busy state, and a second erase issued inside that window can be seen to be dropped. Both values also keep the full unlock, erase and program sequence within a few thousand clocks.

// File: rtl/isc_tap_ctrl.sv
module isc_tap_ctrl #(
  parameter int NSECT       = 4,
  parameter int BUSY_CYCLES = 5000,
  parameter int SEL_W       = 24
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic capture_ir,
  input  logic shift_ir,
  input  logic update_ir,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  output logic tdo
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam int LEN_W = $clog2(SEL_W);

  localparam logic [15:0] OP_BYP    = 16'hFFFF;
  localparam logic [15:0] OP_ENTER  = 16'h00E8;
  localparam logic [15:0] OP_LEAVE  = 16'h00F0;
  localparam logic [15:0] OP_ERASE  = 16'h00EC;
  localparam logic [15:0] OP_PROG   = 16'h00EA;
  localparam logic [15:0] OP_STAT   = 16'h00E3;
  localparam logic [15:0] OP_WPROT  = 16'h00F7;
  localparam logic [15:0] OP_BLANK  = 16'h000D;
  localparam logic [15:0] OP_UNLOCK = 16'h55AA;

  logic [15:0]      ir, ir_sr, ir_cap;
  logic [SEL_W-1:0] dr_sr, dr_cap, dr_next, sel;
  logic [LEN_W-1:0] dr_top;
  logic             mode, busy, done, prog_err, cfg_err;
  logic [NSECT-1:0] wp, blank, need_erase;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       wp_pad, blank_pad;

  logic [NSECT-1:0] new_m, ers_ok, ers_bad, prog_ok, prog_bad;
  logic             gate, erase_req, prog_req, unlock_req, wprot_req, op_start;

  assign new_m    = dr_sr[NSECT-1:0];
  assign ers_ok   = new_m & wp;
  assign ers_bad  = new_m & ~wp;
  assign prog_ok  = sel[NSECT-1:0] & wp & ~need_erase;
  assign prog_bad = sel[NSECT-1:0] & ~prog_ok;

  assign gate       = mode & ~busy;
  assign erase_req  = update_dr && (ir == OP_ERASE);
  assign unlock_req = update_dr && (ir == OP_UNLOCK);
  assign wprot_req  = update_dr && (ir == OP_WPROT);
  assign prog_req   = update_ir && (ir_sr == OP_PROG);
  assign op_start   = gate && (erase_req || prog_req);

  assign ir_cap = {7'b0, 1'b0, cfg_err, 1'b0, prog_err, ~busy, mode, 3'b001};
  assign tdo    = shift_ir ? ir_sr[0] : dr_sr[0];

  always_comb begin
    wp_pad    = '1;
    blank_pad = '1;
    wp_pad[NSECT-1:0]    = wp;
    blank_pad[NSECT-1:0] = blank;
  end

  always_comb begin
    dr_cap = '0;
    dr_top = '0;
    case (ir)
      OP_ERASE, OP_UNLOCK: begin
        dr_cap = sel;
        dr_top = LEN_W'(SEL_W - 1);
      end
      OP_WPROT: begin
        dr_cap[15:0] = {8'hFF, wp_pad};
        dr_top = LEN_W'(15);
      end
      OP_STAT: begin
        dr_cap[7:0] = {5'b0, done, 2'b00};
        dr_top = LEN_W'(7);
      end
      OP_BLANK: begin
        dr_cap[7:0] = blank_pad;
        dr_top = LEN_W'(7);
      end
      default: ;
    endcase
  end

  always_comb begin
    dr_next = dr_sr >> 1;
    dr_next[dr_top] = tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir    <= OP_BYP;
      ir_sr <= '0;
    end else begin
      if (capture_ir)    ir_sr <= ir_cap;
      else if (shift_ir) ir_sr <= {tdi, ir_sr[15:1]};
      if (update_ir)     ir    <= ir_sr;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dr_sr <= '0;
      sel   <= '0;
    end else begin
      if (capture_dr)    dr_sr <= dr_cap;
      else if (shift_dr) dr_sr <= dr_next;
      if (update_dr && (ir == OP_ERASE || ir == OP_UNLOCK)) sel <= dr_sr;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      mode       <= 1'b0;
      cfg_err    <= 1'b0;
      prog_err   <= 1'b0;
      wp         <= '1;
      blank      <= '1;
      need_erase <= '0;
    end else begin
      if (update_ir && ir_sr == OP_ENTER) begin
        mode    <= 1'b1;
        cfg_err <= 1'b0;
      end
      if (update_ir && ir_sr == OP_LEAVE) mode <= 1'b0;
      if (!mode && (erase_req || prog_req || unlock_req || wprot_req)) cfg_err <= 1'b1;
      if (gate && erase_req) begin
        blank      <= blank & ~ers_ok;
        need_erase <= need_erase & ~ers_ok;
        prog_err   <= |ers_bad;
      end
      if (gate && prog_req) begin
        blank    <= blank | prog_ok;
        prog_err <= |prog_bad;
      end
      if (gate && unlock_req) begin
        wp         <= wp | new_m;
        need_erase <= need_erase | new_m;
      end
      if (mode && wprot_req) wp <= wp & new_m;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (op_start) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= CNT_W'(BUSY_CYCLES);
    end else if (busy) begin
      if (cnt == CNT_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/isc_tap_ctrl_chk.sv
module isc_tap_ctrl_chk #(
  parameter int NSECT = 4,
  parameter int SEL_W = 24
) (
  input logic             tck,
  input logic             trst_n,
  input logic             update_ir,
  input logic             update_dr,
  input logic             capture_dr,
  input logic [15:0]      ir,
  input logic [15:0]      ir_sr,
  input logic             mode,
  input logic             busy,
  input logic             done,
  input logic [NSECT-1:0] blank,
  input logic [SEL_W-1:0] dr_sr
);
  p_enter_mode_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (update_ir && ir_sr == 16'h00E8) |=> mode);

  p_leave_mode_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (update_ir && ir_sr == 16'h00F0) |=> !mode);

  p_busy_not_done_r8: assert property (@(posedge tck) disable iff (!trst_n)
    busy |-> !done);

  p_done_on_expiry_r8: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(busy) |-> done);

  p_bypass_zero_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && ir == 16'hFFFF) |=> (dr_sr[0] == 1'b0));

  p_idle_mode_keeps_blank_r12: assert property (@(posedge tck) disable iff (!trst_n)
    (!mode && (update_ir || update_dr)) |=> $stable(blank));
endmodule

bind isc_tap_ctrl isc_tap_ctrl_chk #(.NSECT(NSECT), .SEL_W(SEL_W)) chk_i (
  .tck(tck), .trst_n(trst_n), .update_ir(update_ir), .update_dr(update_dr),
  .capture_dr(capture_dr), .ir(ir), .ir_sr(ir_sr), .mode(mode), .busy(busy),
  .done(done), .blank(blank), .dr_sr(dr_sr)
);

// File: tb/isc_tap_ctrl_tb_top.sv
module isc_tap_ctrl_tb_top;
  localparam int TCK_PERIOD = 10;
  localparam int NS = 3;
  localparam int BC = 100;

  logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
  logic cir = 1'b0, sir = 1'b0, uir = 1'b0, cdr = 1'b0, sdr = 1'b0, udr = 1'b0;
  logic tdo;

  isc_tap_ctrl #(.NSECT(NS), .BUSY_CYCLES(BC), .SEL_W(24)) dut_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture_ir(cir), .shift_ir(sir), .update_ir(uir),
    .capture_dr(cdr), .shift_dr(sdr), .update_dr(udr), .tdo(tdo)
  );

  always #(TCK_PERIOD/2) tck = ~tck;

  int cyc = 0;
  always @(posedge tck) cyc++;

  int total = 0, bad = 0;
  bit finished = 0;

  bit m_mode = 0, m_perr = 0, m_cerr = 0, m_any = 0;
  int m_upd = 0;
  logic [NS-1:0] m_wp = '1, m_blank = '1, m_ne = '0;
  logic [23:0] m_sel = '0;
  logic [15:0] m_ir = 16'hFFFF;

  function automatic bit busy_at(int c);
    return m_any && (c - m_upd) >= 1 && (c - m_upd) <= BC;
  endfunction

  function automatic bit done_at(int c);
    return m_any && (c - m_upd) > BC;
  endfunction

  function automatic logic [7:0] pad(logic [NS-1:0] v);
    logic [7:0] r;
    r = '1;
    r[NS-1:0] = v;
    return r;
  endfunction

  task automatic model_ir_update(logic [15:0] v, int u);
    logic [NS-1:0] s, ok;
    if (v == 16'h00E8) begin m_mode = 1; m_cerr = 0; end
    else if (v == 16'h00F0) m_mode = 0;
    else if (v == 16'h00EA) begin
      if (!m_mode) m_cerr = 1;
      else if (!busy_at(u)) begin
        s = m_sel[NS-1:0];
        ok = s & m_wp & ~m_ne;
        m_blank = m_blank | ok;
        m_perr = |(s & ~ok);
        m_upd = u; m_any = 1;
      end
    end
    m_ir = v;
  endtask

  task automatic model_dr_update(logic [23:0] d, int u);
    logic [NS-1:0] s;
    s = d[NS-1:0];
    case (m_ir)
      16'h00EC: begin
        m_sel = d;
        if (!m_mode) m_cerr = 1;
        else if (!busy_at(u)) begin
          m_blank = m_blank & ~(s & m_wp);
          m_ne = m_ne & ~(s & m_wp);
          m_perr = |(s & ~m_wp);
          m_upd = u; m_any = 1;
        end
      end
      16'h55AA: begin
        m_sel = d;
        if (!m_mode) m_cerr = 1;
        else if (!busy_at(u)) begin
          m_wp = m_wp | s;
          m_ne = m_ne | s;
        end
      end
      16'h00F7: begin
        if (!m_mode) m_cerr = 1;
        else m_wp = m_wp & s;
      end
      default: ;
    endcase
  endtask

  task automatic scan(input bit is_ir, input int n, input logic [63:0] din, input string tag);
    int c, u, len;
    logic [63:0] cap, got, exp;
    c = cyc + 1;
    cap = '0;
    if (is_ir) begin
      len = 16;
      cap[15:0] = {7'b0, 1'b0, m_cerr, 1'b0, m_perr, ~busy_at(c), m_mode, 3'b001};
    end else begin
      case (m_ir)
        16'h00EC, 16'h55AA: begin len = 24; cap[23:0] = m_sel; end
        16'h00F7: begin len = 16; cap[15:0] = {8'hFF, pad(m_wp)}; end
        16'h00E3: begin len = 8; cap[7:0] = {5'b0, done_at(c), 2'b00}; end
        16'h000D: begin len = 8; cap[7:0] = pad(m_blank); end
        default:  begin len = 1; end
      endcase
    end
    exp = '0;
    for (int i = 0; i < n; i++) exp[i] = (i < len) ? cap[i] : din[i - len];
    if (is_ir) cir = 1; else cdr = 1;
    @(negedge tck);
    cir = 0; cdr = 0;
    if (is_ir) sir = 1; else sdr = 1;
    got = '0;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      #1 got[i] = tdo;
      @(negedge tck);
    end
    sir = 0; sdr = 0;
    u = cyc + 1;
    if (is_ir) begin uir = 1; model_ir_update(din[15:0], u); end
    else begin udr = 1; model_dr_update(24'(din >> (n - len)), u); end
    @(negedge tck);
    uir = 0; udr = 0;
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge tck);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    trst_n = 1;
    idle(2);
    scan(1, 16, 64'hFFFF, "R1 R2 reset capture");
    scan(0, 1, 64'h0, "R1 reset bypass");
    scan(0, 4, 64'hD, "R4 bypass delay");
    scan(1, 16, 64'h000D, "R11 select blank");
    scan(0, 8, 64'h0, "R1 R11 blank reset");
    scan(1, 16, 64'h00F7, "R9 select wp");
    scan(0, 16, 64'hFFFF, "R1 R9 wp reset");
    scan(1, 16, 64'h00EC, "R5 select sel");
    scan(0, 24, 64'h5, "R5 R12 erase outside mode");
    scan(0, 24, 64'h3, "R5 sel readback");
    scan(1, 16, 64'h000D, "R2 R12 config error flag");
    scan(0, 8, 64'h0, "R12 blank unchanged");
    scan(1, 16, 64'h00E8, "R3 enter");
    scan(1, 16, 64'h0012, "R3 mode shown");
    scan(0, 3, 64'h3, "R4 unknown opcode bypass");
    scan(1, 16, 64'h00F7, "R9 select wp");
    scan(0, 16, 64'hFFFE, "R9 protect sector 0");
    scan(0, 16, 64'hFFFF, "R9 readback protected");
    scan(0, 16, 64'hFFFF, "R9 cannot unprotect");
    scan(1, 16, 64'h00EC, "R6 select sel");
    scan(0, 24, 64'h3, "R6 erase with protected sector");
    scan(1, 16, 64'h00E3, "R2 R8 busy shown");
    scan(0, 8, 64'h0, "R8 done low while busy");
    scan(1, 16, 64'h00EC, "R8 select sel while busy");
    scan(0, 24, 64'h4, "R8 erase while busy ignored");
    idle(BC + 4);
    scan(1, 16, 64'h00E3, "R6 R8 program error and idle");
    scan(0, 8, 64'h0, "R8 done after expiry");
    scan(1, 16, 64'h000D, "R6 select blank");
    scan(0, 8, 64'h0, "R6 R8 blank after erase");
    scan(1, 16, 64'h55AA, "R10 select unlock");
    scan(0, 24, 64'h1, "R10 unlock sector 0");
    scan(1, 16, 64'h00F7, "R10 select wp");
    scan(0, 16, 64'hFFFF, "R10 protection removed");
    scan(1, 16, 64'h00EA, "R10 program before erase");
    idle(BC + 4);
    scan(1, 16, 64'h000D, "R10 R7 program refused flag");
    scan(0, 8, 64'h0, "R10 blank untouched");
    scan(1, 16, 64'h00EC, "R6 select sel");
    scan(0, 24, 64'h1, "R6 erase unlocked sector");
    idle(BC + 4);
    scan(1, 16, 64'h00EA, "R6 R7 start program");
    scan(1, 16, 64'h00E3, "R7 R8 busy after program");
    scan(0, 8, 64'h0, "R8 done cleared on start");
    idle(BC + 4);
    scan(1, 16, 64'h000D, "R7 no program error");
    scan(0, 8, 64'h0, "R7 blank after program");
    scan(1, 16, 64'h00F0, "R3 leave");
    scan(1, 16, 64'h00EA, "R3 mode off shown");
    scan(1, 16, 64'h000D, "R12 program outside mode");
    scan(0, 8, 64'h0, "R12 blank unchanged");
    scan(1, 16, 64'hFFFF, "R2 R12 config error set");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule